// File: doc/BRIEF.md
# Multi-queue ADC result dispatcher

This block sorts tagged ADC conversion results into four result queues so that software or a DMA engine can pick up each kind of acquisition (for example fast current samples and slow housekeeping samples) from its own place. Each incoming result carries a queue selector, a one-bit converter-unit identifier, a four-bit channel number and a 10-bit conversion value. Two queues are deep (16 entries) for high-rate acquisitions and two are shallow (4 entries) for low-rate ones.

Software reads a queue through a small word-addressed register bus. Each queue is visible at two word addresses: one returns the value right-justified and unsigned, the other returns it left-justified in signed form with a zero sign bit. A 16-bit read returns only the formatted value; a 32-bit read adds the unit and channel tag in the upper half-word. Every queue raises its own interrupt and DMA request while it holds data and is enabled, and keeps a sticky overflow flag that software clears by writing one to it. Queues take results only while the command-driven control mode input is high.

Top module: `adc_result_dispatcher`

## Requirements
- R1: A result presented with `resValid` high while `ctrlMode` is high is appended to the queue numbered by `resQueue` (0 to 3) at the next clock edge, and no other queue changes.
- R2: Queues 0 and 1 hold 16 entries, queues 2 and 3 hold 4 entries; the status full bit of a queue is set exactly when it holds its depth in entries.
- R3: A result presented while `ctrlMode` is low changes no queue and no flag.
- R4: A result sent to a full queue is discarded and sets that queue's overflow bit (status bits [3:0], bit i for queue i); the bit stays set until a write to the status word (address 8) with a one in that bit position.
- R5: A read with `busSize` low returns zeros in bits [31:16]; with `busSize` high bits [19:16] hold the channel, bit 20 the unit, bits [31:21] zero.
- R6: A read at word address i (0 to 3) returns the head of queue i right-justified: value in bits [9:0], bits [15:10] zero.
- R7: A read at word address 4+i returns the head of queue i left-justified: bit 15 zero, value in bits [14:5], bits [4:0] zero.
- R8: A queue read at either address removes the head entry, so entries leave in arrival order; a read of an empty queue returns zero and changes nothing.
- R9: `irqOut[i]` and `dmaReq[i]` are high exactly while queue i is non-empty and enable bit i is set; enables are bits [3:0] of the control word at address 9, readable back there.
- R10: The status word at address 8 reports overflow in bits [3:0], full in bits [11:8] and empty in bits [19:16], one bit per queue in queue order; reading it pops nothing.
- R11: After reset all queues are empty, all overflow bits and enables are zero, and every interrupt and DMA request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlMode | input | 1 | High while the command-driven control mode is active |
| resValid | input | 1 | Result strobe |
| resQueue | input | 2 | Target queue of the result |
| resUnit | input | 1 | Converter unit identifier |
| resChan | input | 4 | Channel number |
| resData | input | 10 | Conversion value |
| busSel | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Word address |
| busSize | input | 1 | Read size: 0 = 16-bit, 1 = 32-bit |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of the read |
| irqOut | output | 4 | Per-queue interrupt |
| dmaReq | output | 4 | Per-queue DMA request |

## Verification
On every cycle the assertions hold the queue occupancy within its depth, keep full and empty exclusive, keep a full queue's occupancy unchanged when a new result is refused, keep an empty queue empty when it is read, and keep a raised overflow flag set until its clear strobe. Only the bench scenarios can show that values come back in arrival order with the right tag and justification for each read size and address, that the shallow and deep queues fill at their own depths, that the mode input gates writes, and that interrupt and DMA lines follow the enable bits.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
  localparam int NUM_Q  = 4;
  localparam int QSEL_W = 2;
  localparam int CHAN_W = 4;
  localparam int WADR_W = 4;

  // word addresses of the non-queue registers
  localparam logic [WADR_W-1:0] ADDR_STATUS = 4'd8;
  localparam logic [WADR_W-1:0] ADDR_CTRL   = 4'd9;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_QUEUE  = 2'd1,
    RD_STATUS = 2'd2,
    RD_CTRL   = 2'd3
  } rdKind_e;

  typedef struct packed {
    logic [NUM_Q-1:0]  push;
    logic [NUM_Q-1:0]  pop;
    logic [NUM_Q-1:0]  ovfClr;
    logic              enWr;
    logic [NUM_Q-1:0]  enVal;
    rdKind_e           rdKind;
    logic [QSEL_W-1:0] rdQueue;
    logic              fmtLeft;
    logic              wide;
  } strobes_t;
endpackage

// File: rtl/adcq_fifo.sv
module adcq_fifo #(
  parameter int WIDTH = 15,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty,
  output logic             dropped
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doPush, doPop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign dropped = push && full;
  assign rdData  = mem[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    32'(count) <= DEPTH);
  a_r10_full_empty_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));
  a_r4_full_refuses: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> (count == $past(count)));
  a_r8_empty_read_holds: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/adcq_ctrl.sv
module adcq_ctrl
  import adcq_pkg::*;
(
  input  logic              ctrlMode,
  input  logic              resValid,
  input  logic [QSEL_W-1:0] resQueue,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [WADR_W-1:0] busAddr,
  input  logic              busSize,
  input  logic [31:0]       busWdata,
  output strobes_t          stb
);
  logic isQueueAddr, rdAct, wrAct;
  logic unusedWdata;

  assign isQueueAddr = (busAddr < WADR_W'(2 * NUM_Q));
  assign rdAct       = busSel && !busWrite;
  assign wrAct       = busSel && busWrite;
  assign unusedWdata = ^busWdata[31:NUM_Q];

  always_comb begin
    stb = '0;
    for (int i = 0; i < NUM_Q; i++) begin
      stb.push[i] = resValid && ctrlMode && (resQueue == QSEL_W'(i));
      stb.pop[i]  = rdAct && isQueueAddr && (busAddr[QSEL_W-1:0] == QSEL_W'(i));
    end
    stb.ovfClr  = (wrAct && busAddr == ADDR_STATUS) ? busWdata[NUM_Q-1:0] : '0;
    stb.enWr    = wrAct && (busAddr == ADDR_CTRL);
    stb.enVal   = busWdata[NUM_Q-1:0];
    stb.rdQueue = busAddr[QSEL_W-1:0];
    stb.fmtLeft = busAddr[QSEL_W];
    stb.wide    = busSize;
    if (!rdAct)                      stb.rdKind = RD_NONE;
    else if (isQueueAddr)            stb.rdKind = RD_QUEUE;
    else if (busAddr == ADDR_STATUS) stb.rdKind = RD_STATUS;
    else if (busAddr == ADDR_CTRL)   stb.rdKind = RD_CTRL;
    else                             stb.rdKind = RD_NONE;
  end
endmodule

// File: rtl/adcq_datapath.sv
module adcq_datapath
  import adcq_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int BIG_DEPTH   = 16,
  parameter int SMALL_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic              resUnit,
  input  logic [CHAN_W-1:0] resChan,
  input  logic [RES_W-1:0]  resData,
  output logic [31:0]       busRdata,
  output logic [NUM_Q-1:0]  irqOut,
  output logic [NUM_Q-1:0]  dmaReq
);
  localparam int ENT_W = 1 + CHAN_W + RES_W;

  logic [ENT_W-1:0] headData [NUM_Q];
  logic [NUM_Q-1:0] fullVec, emptyVec, dropVec;
  logic [NUM_Q-1:0] ovfFlag, enReg;
  logic [ENT_W-1:0] newEntry;

  assign newEntry = {resUnit, resChan, resData};

  for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
    localparam int QD = (g < 2) ? BIG_DEPTH : SMALL_DEPTH;
    adcq_fifo #(.WIDTH(ENT_W), .DEPTH(QD)) u_fifo (
      .clk     (clk),
      .rstN    (rstN),
      .push    (stb.push[g]),
      .pop     (stb.pop[g]),
      .wrData  (newEntry),
      .rdData  (headData[g]),
      .full    (fullVec[g]),
      .empty   (emptyVec[g]),
      .dropped (dropVec[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= '0;
      enReg   <= '0;
    end else begin
      ovfFlag <= (ovfFlag & ~stb.ovfClr) | dropVec;
      if (stb.enWr) enReg <= stb.enVal;
    end
  end

  assign irqOut = ~emptyVec & enReg;
  assign dmaReq = ~emptyVec & enReg;

  logic [ENT_W-1:0] head;
  logic [RES_W-1:0] val;
  logic [15:0]      halfWord, tagWord;

  always_comb begin
    head     = headData[stb.rdQueue];
    val      = head[RES_W-1:0];
    halfWord = stb.fmtLeft ? {1'b0, val, {(15-RES_W){1'b0}}}
                           : {{(16-RES_W){1'b0}}, val};
    tagWord  = {{(16-1-CHAN_W){1'b0}}, head[ENT_W-1:RES_W]};
    case (stb.rdKind)
      RD_QUEUE:  busRdata = emptyVec[stb.rdQueue] ? 32'h0
                          : (stb.wide ? {tagWord, halfWord} : {16'h0, halfWord});
      RD_STATUS: busRdata = {12'h0, emptyVec, 4'h0, fullVec, 4'h0, ovfFlag};
      RD_CTRL:   busRdata = {{(32-NUM_Q){1'b0}}, enReg};
      default:   busRdata = 32'h0;
    endcase
  end

  for (genvar g = 0; g < NUM_Q; g++) begin : g_chk
    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (ovfFlag[g] && !stb.ovfClr[g]) |=> ovfFlag[g]);
  end
endmodule

// File: rtl/adc_result_dispatcher.sv
module adc_result_dispatcher
  import adcq_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int BIG_DEPTH   = 16,
  parameter int SMALL_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlMode,
  input  logic              resValid,
  input  logic [QSEL_W-1:0] resQueue,
  input  logic              resUnit,
  input  logic [CHAN_W-1:0] resChan,
  input  logic [RES_W-1:0]  resData,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [WADR_W-1:0] busAddr,
  input  logic              busSize,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [NUM_Q-1:0]  irqOut,
  output logic [NUM_Q-1:0]  dmaReq
);
  strobes_t stb;

  adcq_ctrl u_ctrl (
    .ctrlMode (ctrlMode),
    .resValid (resValid),
    .resQueue (resQueue),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busSize  (busSize),
    .busWdata (busWdata),
    .stb      (stb)
  );

  adcq_datapath #(
    .RES_W       (RES_W),
    .BIG_DEPTH   (BIG_DEPTH),
    .SMALL_DEPTH (SMALL_DEPTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .resUnit  (resUnit),
    .resChan  (resChan),
    .resData  (resData),
    .busRdata (busRdata),
    .irqOut   (irqOut),
    .dmaReq   (dmaReq)
  );
endmodule

// File: tb/adc_result_dispatcher_test.sv
`timescale 1ns/1ps
module adc_result_dispatcher_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        ctrlMode = 0, resValid = 0, resUnit = 0;
  logic [1:0]  resQueue = 0;
  logic [3:0]  resChan = 0;
  logic [9:0]  resData = 0;
  logic        busSel = 0, busWrite = 0, busSize = 0;
  logic [3:0]  busAddr = 0;
  logic [31:0] busWdata = 0;
  logic [31:0] busRdata;
  logic [3:0]  irqOut, dmaReq;

  int testCnt = 0, failCnt = 0;

  // scoreboard model
  logic [14:0] mq [4][$];
  logic [3:0]  mOvf = 0, mEn = 0;

  always #10 clk = ~clk;

  adc_result_dispatcher uut (
    .clk(clk), .rstN(rstN), .ctrlMode(ctrlMode), .resValid(resValid),
    .resQueue(resQueue), .resUnit(resUnit), .resChan(resChan), .resData(resData),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr), .busSize(busSize),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .dmaReq(dmaReq)
  );

  function automatic int dep(int q);
    return (q < 2) ? 16 : 4;
  endfunction

  function automatic logic [31:0] fmt(logic [14:0] e, bit left, bit wide);
    logic [15:0] hw;
    hw = left ? {1'b0, e[9:0], 5'b0} : {6'b0, e[9:0]};
    return wide ? {11'b0, e[14], e[13:10], hw} : {16'h0, hw};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pushRes(int q, bit unit, int chan, int data);
    @(negedge clk);
    resValid = 1; resQueue = 2'(q); resUnit = unit; resChan = 4'(chan); resData = 10'(data);
    if (ctrlMode) begin
      if (mq[q].size() < dep(q)) mq[q].push_back({unit, 4'(chan), 10'(data)});
      else mOvf[q] = 1'b1;
    end
    @(negedge clk);
    resValid = 0;
  endtask

  task automatic busWr(int addr, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 4'(addr); busWdata = d;
    if (addr == 8) mOvf = mOvf & ~d[3:0];
    if (addr == 9) mEn = d[3:0];
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic regRd(string req, int addr, logic [31:0] exp);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = 4'(addr); busSize = 1;
    #1 chk(req, busRdata, exp);
    @(negedge clk);
    busSel = 0;
  endtask

  // read a queue; expected value popped from the scoreboard
  task automatic qRd(string req, int q, bit left, bit wide);
    logic [31:0] exp;
    exp = 0;
    if (mq[q].size() > 0) exp = fmt(mq[q].pop_front(), left, wide);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = 4'(left ? q + 4 : q); busSize = wide;
    #1 chk(req, busRdata, exp);
    @(negedge clk);
    busSel = 0;
  endtask

  function automatic logic [31:0] expStatus();
    logic [3:0] f, e;
    for (int i = 0; i < 4; i++) begin
      f[i] = (mq[i].size() == dep(i));
      e[i] = (mq[i].size() == 0);
    end
    return {12'h0, e, 4'h0, f, 4'h0, mOvf};
  endfunction

  task automatic checkState(string req);
    logic [3:0] ne;
    for (int i = 0; i < 4; i++) ne[i] = (mq[i].size() != 0);
    regRd({req, "/R10 status"}, 8, expStatus());
    chk({req, "/R9 irq"}, {28'h0, irqOut}, {28'h0, ne & mEn});
    chk({req, "/R9 dma"}, {28'h0, dmaReq}, {28'h0, ne & mEn});
  endtask

  initial begin
    #(200000 * 20);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R11 reset state
    checkState("R11");
    regRd("R11 enables", 9, 32'h0);

    busWr(9, 32'hF);
    regRd("R9 enable readback", 9, 32'hF);
    ctrlMode = 1;

    // R1 routing to each queue
    pushRes(0, 0, 3, 10'h155);
    pushRes(1, 1, 15, 10'h3FF);
    pushRes(2, 0, 0, 10'h001);
    pushRes(3, 1, 7, 10'h200);
    checkState("R1");

    // R5/R6/R7 formats
    qRd("R6 R5 right 16-bit", 0, 0, 0);
    qRd("R7 R5 left 32-bit", 1, 1, 1);
    qRd("R6 R5 right 32-bit", 2, 0, 1);
    qRd("R7 R5 left 16-bit", 3, 1, 0);
    checkState("R8 drained");

    // R8 empty read
    qRd("R8 empty read", 0, 0, 1);
    checkState("R8 empty unchanged");

    // R8 order
    pushRes(0, 1, 9, 10'h011);
    pushRes(0, 0, 4, 10'h022);
    pushRes(0, 1, 2, 10'h033);
    qRd("R8 order 1", 0, 0, 1);
    qRd("R8 order 2", 0, 1, 1);
    qRd("R8 order 3", 0, 0, 1);

    // R2/R4 shallow queue overflow
    for (int i = 0; i < 5; i++) pushRes(2, i[0], i, 10'h100 + i);
    checkState("R2 R4 shallow full");
    busWr(8, 32'h4);
    checkState("R4 w1c");
    qRd("R2 shallow read", 2, 1, 1);
    pushRes(2, 1, 11, 10'h2AA);
    checkState("R4 no ovf after room");

    // R2/R4 deep queue overflow
    for (int i = 0; i < 17; i++) pushRes(0, 0, i % 16, 10'h3C0 + i);
    checkState("R2 R4 deep full");
    busWr(8, 32'h2); // clearing another bit leaves bit 0 set
    checkState("R4 sticky");

    // R3 mode gate
    ctrlMode = 0;
    pushRes(3, 1, 5, 10'h0AB);
    pushRes(0, 1, 5, 10'h0AB);
    checkState("R3 mode low");
    ctrlMode = 1;

    // R9 enables
    busWr(9, 32'h0);
    checkState("R9 disabled");
    busWr(9, 32'h5);
    checkState("R9 partial");

    // drain
    for (int i = 0; i < 16; i++) qRd("R8 drain deep", 0, i[0], i[1]);
    for (int i = 0; i < 4; i++) qRd("R8 drain shallow", 2, i[1], i[0]);
    busWr(8, 32'hF);
    checkState("R4 R8 final");

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule